// File: doc/BRIEF.md
# Prescaled Reloadable Wake-up Timer

This block is a free-running system timer that raises a periodic interrupt and a wake-up request. It holds one 23-bit down counter. The low seven bits divide the selected tick by 128. The upper sixteen bits count whole prescaler periods. When the whole counter passes zero, it reloads from a 16-bit reload value that software writes, and an underflow flag is set. With a reload value R and a tick on every cycle, the flag is set once every 128*(R+1) ticks.

The tick source is chosen by a 2-bit select field. It picks one of four clock-enable inputs when the CPU runs from an internal oscillator; otherwise the CPU clock enable is used. The select field is locked while the timer runs. A single control write that turns the timer on may still change it. Software reaches a byte-wide register window: control, reload high and low, and the upper counter high and low. Only the power-on and watchdog reset inputs return the timer to its defaults.

Top module: `wkup_tmr`

## Requirements
- R1: When `por_n` or `wdt_rst_n` is low at a clock edge, the timer takes its defaults: control reads 0x00, reload high and low read 0xFF, and counter high and low read 0xFF (counter all ones).
- R2: While enabled, each selected tick decrements the 23-bit counter by one. The counter high/low bytes (addresses 3 and 4) show bits 22:7, and the flag rises on tick 128*(R+1) after enable.
- R3: A tick with the counter at zero reloads the upper 16 bits from the reload value and the prescaler to 0x7F, and sets the flag (control bit 7).
- R4: A control write (address 0) that sets bit 0 while the timer is off loads the upper counter from the reload value and the prescaler with 0x7F. While off, the counter holds.
- R5: When `int_osc_i` is 1, ticks come from `src_en_i[sel]`; when it is 0, ticks come from `cclk_en_i`. Other enable inputs have no effect.
- R6: Select bits 6:5 of a control write are ignored while enable is already 1. A write that turns the timer on from off takes the new select.
- R7: A control write with bit 7 at 0 clears the flag, and bit 7 at 1 leaves it. An underflow in the same cycle keeps the flag set.
- R8: `irq_o` is 1 exactly when the flag, interrupt enable (control bit 1), `periph_ie_i` and `global_ie_i` are all 1.
- R9: `wake_o` is 1 exactly when the flag and interrupt enable are both 1.
- R10: Reload high/low sit at addresses 1/2 (read and write). Control reads back {flag, select[1:0], 3'b000, int enable, enable}. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| wdt_rst_n | input | 1 | Watchdog reset, active low, synchronous |
| int_osc_i | input | 1 | CPU runs from an internal oscillator |
| src_en_i | input | 4 | Clock enables of the internal oscillator sources |
| cclk_en_i | input | 1 | CPU clock enable |
| periph_ie_i | input | 1 | Peripheral interrupt enable from the interrupt controller |
| global_ie_i | input | 1 | Global interrupt enable |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake-up request |

## Verification
The bench builds the block with its default widths: a 7-bit prescaler, a 16-bit upper section and a 2-bit select. It uses small reload values (0, 1 and 2), so a full underflow period takes only 128 to 384 ticks. That keeps many reloads within reach, including underflows that land in the same cycle as a flag-clearing write. It also toggles source enables and the CPU clock enable, so that ticks from unselected sources are shown to be ignored. A random phase mixes register writes, source switching and occasional resets.

// File: rtl/wkup_tmr_pkg.sv
package wkup_tmr_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_RLD_HI = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_RLD_LO = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_CNT_HI = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_CNT_LO = 3'd4;

    localparam int CB_EN     = 0;
    localparam int CB_IE     = 1;
    localparam int CB_SEL_LO = 5;
    localparam int CB_FLAG   = 7;
endpackage

// File: rtl/wkup_tmr_clksel.sv
module wkup_tmr_clksel #(
    parameter  int SEL_W = 2,
    localparam int NSRC  = 1 << SEL_W
) (
    input  logic             int_osc_i,
    input  logic [NSRC-1:0]  src_en_i,
    input  logic             cclk_en_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    logic [NSRC-1:0] hit;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign hit[g] = src_en_i[g] && (sel_i == SEL_W'(g));
    end

    always_comb begin
        if (int_osc_i) tick_o = |hit;
        else           tick_o = cclk_en_i;
    end
endmodule

// File: rtl/wkup_tmr_regs.sv
module wkup_tmr_regs
    import wkup_tmr_pkg::*;
#(
    parameter  int DATA_W = 8,
    parameter  int SEL_W  = 2,
    localparam int CNT_W  = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              uf_i,
    output logic              en_o,
    output logic              ie_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic              flag_o,
    output logic [CNT_W-1:0]  rld_o,
    output logic              load_o
);
    typedef struct packed {
        logic             en;
        logic             ie;
        logic [SEL_W-1:0] sel;
        logic             flag;
        logic [CNT_W-1:0] rld;
    } regs_t;

    regs_t st_d, st_q;
    logic  ctrl_wr;

    always_comb begin
        st_d    = st_q;
        ctrl_wr = wr_i && (addr_i == ADDR_CTRL);
        load_o  = ctrl_wr && wdata_i[CB_EN] && !st_q.en;

        if (ctrl_wr) begin
            st_d.en = wdata_i[CB_EN];
            st_d.ie = wdata_i[CB_IE];
            if (!st_q.en) st_d.sel = wdata_i[CB_SEL_LO +: SEL_W];
            if (!wdata_i[CB_FLAG]) st_d.flag = 1'b0;
        end
        if (uf_i) st_d.flag = 1'b1;

        if (wr_i && (addr_i == ADDR_RLD_HI)) st_d.rld[CNT_W-1:DATA_W] = wdata_i;
        if (wr_i && (addr_i == ADDR_RLD_LO)) st_d.rld[DATA_W-1:0]     = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.en   <= 1'b0;
            st_q.ie   <= 1'b0;
            st_q.sel  <= '0;
            st_q.flag <= 1'b0;
            st_q.rld  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o   = st_q.en;
    assign ie_o   = st_q.ie;
    assign sel_o  = st_q.sel;
    assign flag_o = st_q.flag;
    assign rld_o  = st_q.rld;
endmodule

// File: rtl/wkup_tmr_count.sv
module wkup_tmr_count #(
    parameter int PRE_W = 7,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] rld_i,
    output logic [CNT_W-1:0] upper_o,
    output logic [PRE_W-1:0] pre_o,
    output logic             uf_o
);
    typedef struct packed {
        logic [CNT_W-1:0] upper;
        logic [PRE_W-1:0] pre;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        uf_o = 1'b0;
        if (load_i) begin
            st_d.upper = rld_i;
            st_d.pre   = '1;
        end else if (en_i && tick_i) begin
            if (st_q.pre == '0) begin
                st_d.pre = '1;
                if (st_q.upper == '0) begin
                    st_d.upper = rld_i;
                    uf_o       = 1'b1;
                end else begin
                    st_d.upper = st_q.upper - 1'b1;
                end
            end else begin
                st_d.pre = st_q.pre - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.upper <= '1;
            st_q.pre   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign upper_o = st_q.upper;
    assign pre_o   = st_q.pre;
endmodule

// File: rtl/wkup_tmr.sv
module wkup_tmr
    import wkup_tmr_pkg::*;
#(
    parameter  int DATA_W = 8,
    parameter  int PRE_W  = 7,
    parameter  int SEL_W  = 2,
    localparam int NSRC   = 1 << SEL_W,
    localparam int CNT_W  = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              wdt_rst_n,
    input  logic              int_osc_i,
    input  logic [NSRC-1:0]   src_en_i,
    input  logic              cclk_en_i,
    input  logic              periph_ie_i,
    input  logic              global_ie_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o,
    output logic              wake_o
);
    logic             rst_n;
    logic             tick;
    logic             en, ie, flag, uf, load;
    logic [SEL_W-1:0] sel;
    logic [CNT_W-1:0] rld, upper;
    logic [PRE_W-1:0] pre;

    assign rst_n = por_n & wdt_rst_n;

    wkup_tmr_clksel #(.SEL_W(SEL_W)) u_clksel (
        .int_osc_i (int_osc_i),
        .src_en_i  (src_en_i),
        .cclk_en_i (cclk_en_i),
        .sel_i     (sel),
        .tick_o    (tick)
    );

    wkup_tmr_regs #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .uf_i    (uf),
        .en_o    (en),
        .ie_o    (ie),
        .sel_o   (sel),
        .flag_o  (flag),
        .rld_o   (rld),
        .load_o  (load)
    );

    wkup_tmr_count #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en),
        .tick_i  (tick),
        .load_i  (load),
        .rld_i   (rld),
        .upper_o (upper),
        .pre_o   (pre),
        .uf_o    (uf)
    );

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_CTRL: begin
                rdata_o[CB_EN]                = en;
                rdata_o[CB_IE]                = ie;
                rdata_o[CB_SEL_LO +: SEL_W]   = sel;
                rdata_o[CB_FLAG]              = flag;
            end
            ADDR_RLD_HI: rdata_o = rld[CNT_W-1:DATA_W];
            ADDR_RLD_LO: rdata_o = rld[DATA_W-1:0];
            ADDR_CNT_HI: rdata_o = upper[CNT_W-1:DATA_W];
            ADDR_CNT_LO: rdata_o = upper[DATA_W-1:0];
            default:     rdata_o = '0;
        endcase
    end

    assign wake_o = flag & ie;
    assign irq_o  = flag & ie & periph_ie_i & global_ie_i;
endmodule

// File: rtl/wkup_tmr_chk.sv
module wkup_tmr_chk #(
    parameter int PRE_W = 7,
    parameter int CNT_W = 16,
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             tick,
    input logic             load,
    input logic             uf,
    input logic             flag,
    input logic [SEL_W-1:0] sel,
    input logic [CNT_W-1:0] rld,
    input logic [CNT_W-1:0] upper,
    input logic [PRE_W-1:0] pre,
    input logic             irq_o,
    input logic             wake_o
);
    p_irq_implies_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> wake_o);

    p_wake_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> flag);

    p_sel_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (sel == $past(sel)));

    p_load_on_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (en && upper == $past(rld) && pre == '1));

    p_hold_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load) |=> (upper == $past(upper) && pre == $past(pre)));

    p_underflow_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        uf |=> (flag && pre == '1 && upper == $past(rld)));

    p_prescale_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && pre != '0) |=> (pre == $past(pre) - 1'b1 && upper == $past(upper)));
endmodule

bind wkup_tmr wkup_tmr_chk #(.PRE_W(PRE_W), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .tick   (tick),
    .load   (load),
    .uf     (uf),
    .flag   (flag),
    .sel    (sel),
    .rld    (rld),
    .upper  (upper),
    .pre    (pre),
    .irq_o  (irq_o),
    .wake_o (wake_o)
);

// File: tb/wkup_tmr_tb.sv
module wkup_tmr_tb;
    logic       clk = 1'b0;
    logic       por_n = 1'b0, wdt_rst_n = 1'b1;
    logic       int_osc = 1'b1, cclk_en = 1'b1;
    logic [3:0] src_en = 4'b0000;
    logic       periph_ie = 1'b0, global_ie = 1'b0;
    logic       wr = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq, wake;

    int n_tests = 0, n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    wkup_tmr u_dut (
        .clk(clk), .por_n(por_n), .wdt_rst_n(wdt_rst_n), .int_osc_i(int_osc),
        .src_en_i(src_en), .cclk_en_i(cclk_en), .periph_ie_i(periph_ie),
        .global_ie_i(global_ie), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq), .wake_o(wake)
    );

    // Behavioural reference: one integer for the whole 23-bit counter
    bit m_en, m_ie, m_flag, started;
    int m_sel, m_rld, m_cnt;
    bit m_tick, m_uf;

    always @(posedge clk) begin
        if (!por_n || !wdt_rst_n) begin
            m_en <= 0; m_ie <= 0; m_flag <= 0; m_sel <= 0;
            m_rld <= 65535; m_cnt <= (1 << 23) - 1; started <= 1;
        end else begin
            m_tick = int_osc ? src_en[m_sel] : cclk_en;
            m_uf   = m_en && m_tick && (m_cnt == 0);
            if (wr && addr == 3'd0 && wdata[0] && !m_en)
                m_cnt <= m_rld * 128 + 127;
            else if (m_en && m_tick)
                m_cnt <= (m_cnt == 0) ? m_rld * 128 + 127 : m_cnt - 1;
            if (wr && addr == 3'd0) begin
                m_en <= wdata[0];
                m_ie <= wdata[1];
                if (!m_en) m_sel <= int'(wdata[6:5]);
            end
            if (m_uf) m_flag <= 1;
            else if (wr && addr == 3'd0 && !wdata[7]) m_flag <= 0;
            if (wr && addr == 3'd1) m_rld <= (m_rld & 255) | (int'(wdata) << 8);
            if (wr && addr == 3'd2) m_rld <= (m_rld & 65280) | int'(wdata);
        end
    end

    function automatic logic [7:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return {m_flag, 2'(m_sel), 3'b000, m_ie, m_en};
            3'd1: return 8'((m_rld >> 8) & 255);
            3'd2: return 8'(m_rld & 255);
            3'd3: return 8'((m_cnt >> 15) & 255);
            3'd4: return 8'((m_cnt >> 7) & 255);
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference model
    always @(negedge clk) begin
        if (started && !finished) begin
            chk({7'd0, irq}, {7'd0, m_flag & m_ie & periph_ie & global_ie}, "R8 irq");
            chk({7'd0, wake}, {7'd0, m_flag & m_ie}, "R9 wake");
            case (addr)
                3'd0:       chk(rdata, exp_rd(addr), "R7 ctrl readback");
                3'd3, 3'd4: chk(rdata, exp_rd(addr), "R2 counter readback");
                default:    chk(rdata, exp_rd(addr), "R10 register readback");
            endcase
        end
    end

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [7:0] d);
        wr = 1; addr = a; wdata = d;
        step();
        wr = 0;
    endtask

    task automatic rreg(input logic [2:0] a, input logic [7:0] exp, input string tag);
        addr = a;
        #2;
        chk(rdata, exp, tag);
    endtask

    logic [7:0] held;

    initial begin
        step(3);
        por_n = 1;
        rreg(3'd0, 8'h00, "R1 ctrl default");
        rreg(3'd1, 8'hFF, "R1 reload hi default");
        rreg(3'd2, 8'hFF, "R1 reload lo default");
        rreg(3'd3, 8'hFF, "R1 count hi default");
        rreg(3'd4, 8'hFF, "R1 count lo default");
        rreg(3'd6, 8'h00, "R10 unused address");

        // Internal source select, lock, reload
        periph_ie = 1; global_ie = 1;
        wreg(3'd1, 8'h00);
        wreg(3'd2, 8'h02);
        rreg(3'd2, 8'h02, "R10 reload lo write");
        src_en = 4'b1101;
        wreg(3'd0, 8'h21);
        rreg(3'd0, 8'h21, "R6 select taken with enable");
        rreg(3'd4, 8'h02, "R4 load on enable");
        step(50);
        rreg(3'd4, 8'h02, "R5 unselected sources ignored");
        wreg(3'd0, 8'h41);
        rreg(3'd0, 8'h21, "R6 select locked while running");
        src_en = 4'b0010;
        step(383);
        rreg(3'd0, 8'h21, "R2 no flag before 384 ticks");
        step(1);
        rreg(3'd0, 8'hA1, "R3 flag after 384 ticks");
        rreg(3'd4, 8'h02, "R3 reload after underflow");
        chk({7'd0, irq}, 8'h00, "R8 irq off without enable");
        wreg(3'd0, 8'hA3);
        chk({7'd0, irq}, 8'h01, "R8 irq with all enables");
        global_ie = 0;
        #1;
        chk({7'd0, irq}, 8'h00, "R8 irq gated by global enable");
        chk({7'd0, wake}, 8'h01, "R9 wake ignores global enable");
        wreg(3'd0, 8'h23);
        rreg(3'd0, 8'h23, "R7 flag cleared by write of 0");

        // Disable, hold, change select
        wreg(3'd0, 8'h00);
        addr = 3'd4; #1; held = rdata;
        step(20);
        rreg(3'd4, held, "R4 counter holds while off");
        wreg(3'd0, 8'h40);
        rreg(3'd0, 8'h40, "R6 select writable while off");

        // CPU clock path
        int_osc = 0; cclk_en = 0; src_en = 4'b1111;
        wreg(3'd2, 8'h00);
        wreg(3'd0, 8'h41);
        rreg(3'd4, 8'h00, "R4 load zero reload");
        step(200);
        rreg(3'd0, 8'h41, "R5 internal sources ignored on CPU clock");
        cclk_en = 1;
        step(127);
        rreg(3'd0, 8'h41, "R2 no flag before 128 ticks");
        step(1);
        rreg(3'd0, 8'hC1, "R2 flag after 128 ticks");

        // Flag clear hammered across underflows (R7 priority, checked per cycle)
        for (int i = 0; i < 300; i++) begin
            wr = 1; addr = 3'd0; wdata = 8'h41;
            step();
        end
        wr = 0;

        // Watchdog reset returns defaults
        wdt_rst_n = 0; step(); wdt_rst_n = 1;
        rreg(3'd0, 8'h00, "R1 ctrl after watchdog reset");
        rreg(3'd2, 8'hFF, "R1 reload after watchdog reset");
        rreg(3'd4, 8'hFF, "R1 count after watchdog reset");

        // Random phase
        for (int i = 0; i < 6000; i++) begin
            int_osc   = $urandom_range(0, 3) != 0;
            src_en    = 4'($urandom);
            cclk_en   = $urandom_range(0, 1) != 0;
            periph_ie = $urandom_range(0, 1) != 0;
            global_ie = $urandom_range(0, 1) != 0;
            wr        = $urandom_range(0, 9) == 0;
            addr      = 3'($urandom_range(0, 5));
            wdata     = 8'($urandom);
            if (wr && addr == 3'd2) wdata = 8'($urandom_range(0, 1));
            if (wr && addr == 3'd1) wdata = 8'h00;
            por_n     = $urandom_range(0, 999) != 0;
            step();
        end
        wr = 0; por_n = 1;
        step(2);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule